// File: doc/BRIEF.md
# Compare-and-Skip Word Processor Core

This block is a small processor core. In each clock cycle it fetches, decodes and completes one 32-bit instruction. Its instruction set has ten operations: register add, register NAND, add-immediate, word load, word store, relative jump, jump-and-link through a register, stop, compare-and-skip, and relative address formation. A 16-entry register file, a program counter and a word-addressed memory all live inside the core. Instructions and data share that memory.

Software starts the core by holding reset and writing the program into memory through a plain loader port. When reset is released, execution begins at word 0. Decisions are made with a compare that skips the next instruction when it succeeds; there are no condition flags. The stop instruction raises a sticky halted output. A combinational debug port lets the surroundings read any register at any time. The block has no streaming data path, so every pin is a plain control, status or loader signal.

Top module: `skipcore_top`

## Requirements
- R1: The reset input is synchronous and active high. While it is asserted, at each edge the PC goes to 0, halted goes low and all 16 registers go to 0. Memory keeps its contents through reset. A loader write (`ld_we`) stores `ld_data` into word `ld_addr`, and it takes priority over a store from the core in the same cycle.
- R2: The opcode sits in bits 31:28. Bits 27:24 hold the destination, store source or skip mode. Bits 23:20 hold the first source or base register. Bits 3:0 hold the second source. Bits 19:0 hold a 20-bit immediate, which is always sign-extended. The opcode values are 0 ADD (first+second), 1 NAND (~(first & second)), 2 ADDI (first+immediate), 3 LW, 4 SW, 5 GOTO, 6 JALR, 7 HALT, 8 SKP and 9 LEA. Register and memory writes take effect at the rising edge.
- R3: Register 0 always reads as zero, and writes to it are discarded. `dbg_val` shows the register selected by `dbg_sel` combinationally.
- R4: LW and SW form the address base+immediate and keep only its low 16 bits. That word address is then taken modulo the memory depth (256 words by default). LW writes the word it reads to the destination register. SW stores the register named in bits 27:24.
- R5: GOTO sets the PC to PC+1+immediate. LEA writes PC+1+immediate to its destination. Negative offsets jump backwards.
- R6: JALR writes PC+1 to the register in bits 27:24 and loads the PC from the register in bits 23:20. The jump uses the value that register held before the instruction, even when both fields name the same register.
- R7: In SKP, mode 0 skips when first == second, and mode 1 skips when first < second as signed two's-complement numbers. A skip makes the next PC equal PC+2, and no skip gives PC+1. Any other mode never skips.
- R8: HALT raises `halted` at its own edge. The PC stays on the HALT word. After that, no register or memory changes until reset.
- R9: Opcodes 10 to 15 change nothing except that they advance the PC by one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_we | input | 1 | Loader write strobe |
| ld_addr | input | 16 | Loader word address |
| ld_data | input | 32 | Loader write data |
| dbg_sel | input | 4 | Register index for the debug read |
| dbg_val | output | 32 | Value of the selected register |
| halted | output | 1 | High once a HALT has completed |

## Verification
JALR does two things in a single cycle: it writes the link register and it redirects the PC. The bench provokes the case where both fields name the same register, so the write and the read of the jump target collide. The result is judged by whether execution lands at the old register value while the register afterwards holds the link address. A second collision is a write aimed at register 0, through ADDI and through JALR, and after it register 0 must still read zero. A behavioural model runs in step with the core, and every register plus `halted` is compared against it after each edge.

// File: rtl/skipcore_pkg.sv
package skipcore_pkg;
  localparam int XLEN   = 32;
  localparam int NREG   = 16;
  localparam int RIDX_W = $clog2(NREG);
  localparam int IMM_W  = 20;
  localparam int ADDR_W = 16;

  typedef logic [3:0] opc_t;
  localparam opc_t OP_ADD  = 4'h0;
  localparam opc_t OP_NAND = 4'h1;
  localparam opc_t OP_ADDI = 4'h2;
  localparam opc_t OP_LW   = 4'h3;
  localparam opc_t OP_SW   = 4'h4;
  localparam opc_t OP_GOTO = 4'h5;
  localparam opc_t OP_JALR = 4'h6;
  localparam opc_t OP_HALT = 4'h7;
  localparam opc_t OP_SKP  = 4'h8;
  localparam opc_t OP_LEA  = 4'h9;

  localparam logic [3:0] SKIP_EQ = 4'h0;
  localparam logic [3:0] SKIP_LT = 4'h1;

  typedef struct packed {
    opc_t              op;
    logic [RIDX_W-1:0] rd;
    logic [RIDX_W-1:0] rs1;
    logic [RIDX_W-1:0] rs2;
    logic [XLEN-1:0]   imm;
  } dec_t;
endpackage

// File: rtl/skipcore_decode.sv
module skipcore_decode
  import skipcore_pkg::*;
(
  input  logic [XLEN-1:0] instr,
  output dec_t            dec
);
  always_comb begin
    dec.op  = instr[31:28];
    dec.rd  = instr[27:24];
    dec.rs1 = instr[23:20];
    dec.rs2 = instr[3:0];
    dec.imm = {{(XLEN-IMM_W){instr[IMM_W-1]}}, instr[IMM_W-1:0]};
  end
endmodule

// File: rtl/skipcore_regfile.sv
module skipcore_regfile
  import skipcore_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [RIDX_W-1:0] waddr,
  input  logic [XLEN-1:0]   wdata,
  input  logic [RIDX_W-1:0] ra_a,
  input  logic [RIDX_W-1:0] ra_b,
  input  logic [RIDX_W-1:0] ra_c,
  input  logic [RIDX_W-1:0] ra_d,
  output logic [XLEN-1:0]   rv_a,
  output logic [XLEN-1:0]   rv_b,
  output logic [XLEN-1:0]   rv_c,
  output logic [XLEN-1:0]   rv_d
);
  logic [XLEN-1:0] regs [NREG];

  // Entry 0 is a constant; the others are storage.
  assign regs[0] = '0;
  for (genvar g = 1; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)                                      regs[g] <= '0;
      else if (we && (waddr == RIDX_W'(g)))         regs[g] <= wdata;
    end
  end

  assign rv_a = regs[ra_a];
  assign rv_b = regs[ra_b];
  assign rv_c = regs[ra_c];
  assign rv_d = regs[ra_d];
endmodule

// File: rtl/skipcore_mem.sv
module skipcore_mem
  import skipcore_pkg::*;
#(
  parameter int DEPTH = 256
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [XLEN-1:0]   wdata,
  input  logic [ADDR_W-1:0] iaddr,
  output logic [XLEN-1:0]   idata,
  input  logic [ADDR_W-1:0] daddr,
  output logic [XLEN-1:0]   ddata
);
  localparam int AW = $clog2(DEPTH);

  logic [XLEN-1:0] words [DEPTH];
  logic [AW-1:0]   w_idx, i_idx, d_idx;

  assign w_idx = waddr[AW-1:0];
  assign i_idx = iaddr[AW-1:0];
  assign d_idx = daddr[AW-1:0];

  if (AW < ADDR_W) begin : g_fold
    logic unused_hi;
    assign unused_hi = ^{waddr[ADDR_W-1:AW], iaddr[ADDR_W-1:AW], daddr[ADDR_W-1:AW]};
  end

  always_ff @(posedge clk) begin
    if (we) words[w_idx] <= wdata;
  end

  assign idata = words[i_idx];
  assign ddata = words[d_idx];
endmodule

// File: rtl/skipcore_exec.sv
module skipcore_exec
  import skipcore_pkg::*;
(
  input  dec_t              dec,
  input  logic [XLEN-1:0]   pc,
  input  logic              halted,
  input  logic [XLEN-1:0]   a_val,
  input  logic [XLEN-1:0]   b_val,
  input  logic [XLEN-1:0]   c_val,
  input  logic [XLEN-1:0]   mem_rdata,
  output logic              rf_we,
  output logic [XLEN-1:0]   rf_wdata,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [XLEN-1:0]   mem_wdata,
  output logic [XLEN-1:0]   pc_next,
  output logic              halt_req
);
  logic [XLEN-1:0] pc_inc, pc_rel, ea;
  logic            skip;

  assign pc_inc    = pc + XLEN'(1);
  assign pc_rel    = pc_inc + dec.imm;
  assign ea        = a_val + dec.imm;
  assign mem_addr  = ea[ADDR_W-1:0];
  assign mem_wdata = c_val;

  always_comb begin
    unique case (dec.rd)
      SKIP_EQ: skip = (a_val == b_val);
      SKIP_LT: skip = ($signed(a_val) < $signed(b_val));
      default: skip = 1'b0;
    endcase
  end

  always_comb begin
    rf_we    = 1'b0;
    rf_wdata = '0;
    mem_we   = 1'b0;
    pc_next  = pc_inc;
    halt_req = 1'b0;
    if (halted) begin
      pc_next = pc;
    end else begin
      case (dec.op)
        OP_ADD:  begin rf_we = 1'b1; rf_wdata = a_val + b_val;    end
        OP_NAND: begin rf_we = 1'b1; rf_wdata = ~(a_val & b_val); end
        OP_ADDI: begin rf_we = 1'b1; rf_wdata = ea;               end
        OP_LW:   begin rf_we = 1'b1; rf_wdata = mem_rdata;        end
        OP_SW:   mem_we = 1'b1;
        OP_GOTO: pc_next = pc_rel;
        OP_JALR: begin rf_we = 1'b1; rf_wdata = pc_inc; pc_next = a_val; end
        OP_HALT: begin halt_req = 1'b1; pc_next = pc; end
        OP_SKP:  if (skip) pc_next = pc_inc + XLEN'(1);
        OP_LEA:  begin rf_we = 1'b1; rf_wdata = pc_rel; end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/skipcore_top.sv
module skipcore_top
  import skipcore_pkg::*;
#(
  parameter int MEM_DEPTH = 256
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        ld_we,
  input  logic [15:0] ld_addr,
  input  logic [31:0] ld_data,
  input  logic [3:0]  dbg_sel,
  output logic [31:0] dbg_val,
  output logic        halted
);
  logic [XLEN-1:0]   pc, pc_next, instr, mem_rdata;
  logic [XLEN-1:0]   a_val, b_val, c_val, rf_wdata, mem_wdata;
  logic              rf_we, core_mem_we, halt_req, halt_q;
  logic [ADDR_W-1:0] mem_addr;
  logic              m_we;
  logic [ADDR_W-1:0] m_waddr;
  logic [XLEN-1:0]   m_wdata;
  logic              unused_pc;
  dec_t              dec;

  assign unused_pc = ^pc[XLEN-1:ADDR_W];

  skipcore_decode u_dec (.instr(instr), .dec(dec));

  skipcore_regfile u_rf (
    .clk(clk), .rst(rst),
    .we(rf_we && !rst), .waddr(dec.rd), .wdata(rf_wdata),
    .ra_a(dec.rs1), .ra_b(dec.rs2), .ra_c(dec.rd), .ra_d(dbg_sel),
    .rv_a(a_val), .rv_b(b_val), .rv_c(c_val), .rv_d(dbg_val)
  );

  skipcore_exec u_exe (
    .dec(dec), .pc(pc), .halted(halt_q),
    .a_val(a_val), .b_val(b_val), .c_val(c_val), .mem_rdata(mem_rdata),
    .rf_we(rf_we), .rf_wdata(rf_wdata),
    .mem_we(core_mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .pc_next(pc_next), .halt_req(halt_req)
  );

  // Loader wins the single write port.
  always_comb begin
    if (ld_we) begin
      m_we = 1'b1; m_waddr = ld_addr; m_wdata = ld_data;
    end else begin
      m_we = core_mem_we && !rst; m_waddr = mem_addr; m_wdata = mem_wdata;
    end
  end

  skipcore_mem #(.DEPTH(MEM_DEPTH)) u_mem (
    .clk(clk), .we(m_we), .waddr(m_waddr), .wdata(m_wdata),
    .iaddr(pc[ADDR_W-1:0]), .idata(instr),
    .daddr(mem_addr), .ddata(mem_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc     <= '0;
      halt_q <= 1'b0;
    end else begin
      pc <= pc_next;
      if (halt_req) halt_q <= 1'b1;
    end
  end

  assign halted = halt_q;

  // R8
  halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);
  // R8
  halt_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    halted |-> (!rf_we && !core_mem_we && pc_next == pc));
  // R8
  halt_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (!halted && dec.op == OP_HALT) |=> (halted && $stable(pc)));
  // R3
  zero_reg_chk: assert property (@(posedge clk) disable iff (rst)
    (dbg_sel == 4'd0) |-> (dbg_val == '0));
  // R6
  jalr_target_chk: assert property (@(posedge clk) disable iff (rst)
    (!halted && dec.op == OP_JALR) |=> (pc == $past(a_val)));
  // R7
  skip_eq_chk: assert property (@(posedge clk) disable iff (rst)
    (!halted && dec.op == OP_SKP && dec.rd == SKIP_EQ && a_val == b_val)
      |=> (pc == $past(pc) + XLEN'(2)));
  // R9
  undef_op_chk: assert property (@(posedge clk) disable iff (rst)
    (!halted && dec.op >= 4'hA) |-> (!rf_we && !core_mem_we && pc_next == pc + XLEN'(1)));
endmodule

// File: tb/skipcore_tb_top.sv
`timescale 1ns/100ps
module skipcore_tb_top;
  localparam int DEPTH = 256;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld_we = 1'b0;
  logic [15:0] ld_addr = '0;
  logic [31:0] ld_data = '0;
  logic [3:0]  dbg_sel = '0;
  logic [31:0] dbg_val;
  logic        halted;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // Model state
  logic [31:0] m_reg [16];
  logic [31:0] m_mem [DEPTH];
  logic [31:0] m_pc;
  logic        m_halt;
  string       m_tag = "R1";

  always #10 clk = ~clk;

  skipcore_top dut_i (
    .clk(clk), .rst(rst), .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data),
    .dbg_sel(dbg_sel), .dbg_val(dbg_val), .halted(halted)
  );

  function automatic logic [31:0] sx(input logic [31:0] w);
    return {{12{w[19]}}, w[19:0]};
  endfunction

  function automatic string tag_of(input logic [3:0] op);
    case (op)
      4'h0, 4'h1, 4'h2: return "R2";
      4'h3, 4'h4:       return "R4";
      4'h5, 4'h9:       return "R5";
      4'h6:             return "R6";
      4'h7:             return "R8";
      4'h8:             return "R7";
      default:          return "R9";
    endcase
  endfunction

  initial begin
    for (int i = 0; i < 16; i++) m_reg[i] = '0;
    for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
    m_pc = '0; m_halt = 1'b0;
  end

  // Behavioural reference, one instruction per edge
  always @(posedge clk) begin
    logic [31:0] ins, a, b, c, nxt, ea;
    logic [3:0]  op, rd;
    logic        ld_hit;
    ld_hit = ld_we;
    if (rst) begin
      m_pc = '0; m_halt = 1'b0; m_tag = "R1";
      for (int i = 0; i < 16; i++) m_reg[i] = '0;
    end else if (!m_halt) begin
      ins = m_mem[m_pc[15:0] % DEPTH];
      op = ins[31:28]; rd = ins[27:24];
      a = m_reg[ins[23:20]]; b = m_reg[ins[3:0]]; c = m_reg[rd];
      ea = a + sx(ins);
      nxt = m_pc + 1;
      m_tag = tag_of(op);
      case (op)
        4'h0: m_reg[rd] = a + b;
        4'h1: m_reg[rd] = ~(a & b);
        4'h2: m_reg[rd] = ea;
        4'h3: m_reg[rd] = m_mem[ea[15:0] % DEPTH];
        4'h4: if (!ld_hit) m_mem[ea[15:0] % DEPTH] = c;
        4'h5: nxt = m_pc + 1 + sx(ins);
        4'h6: begin m_reg[rd] = m_pc + 1; nxt = a; end
        4'h7: begin m_halt = 1'b1; nxt = m_pc; end
        4'h8: if ((rd == 4'h0 && a == b) ||
                  (rd == 4'h1 && $signed(a) < $signed(b))) nxt = m_pc + 2;
        4'h9: m_reg[rd] = m_pc + 1 + sx(ins);
        default: ;
      endcase
      m_reg[0] = '0;
      m_pc = nxt;
    end
    if (ld_hit) m_mem[ld_addr % DEPTH] = ld_data;
  end

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic peek(input int r, output logic [31:0] v);
    dbg_sel = 4'(r);
    #0.5;
    v = dbg_val;
  endtask

  // Called right after a falling edge: compare the whole state
  task automatic lockstep();
    logic [31:0] v;
    check({m_tag, " halted"}, {31'b0, halted}, {31'b0, m_halt});
    for (int r = 0; r < 16; r++) begin
      peek(r, v);
      check({m_tag, " reg"}, v, m_reg[r]);
    end
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      lockstep();
    end
  endtask

  task automatic load(input int addr, input logic [31:0] w);
    @(negedge clk);
    ld_we = 1'b1; ld_addr = 16'(addr); ld_data = w;
    @(negedge clk);
    ld_we = 1'b0;
  endtask

  function automatic logic [31:0] rr(input logic [3:0] op, input int d, input int s1, input int s2);
    return {op, 4'(d), 4'(s1), 16'h0, 4'(s2)};
  endfunction
  function automatic logic [31:0] ri(input logic [3:0] op, input int d, input int s1, input int imm);
    return {op, 4'(d), 4'(s1), 20'(imm)};
  endfunction

  task automatic expect_reg(input string tag, input int r, input logic [31:0] exp);
    logic [31:0] v;
    peek(r, v);
    check(tag, v, exp);
  endtask

  initial begin : main
    logic [31:0] v;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    // R1: reset state
    check("R1 halted after reset", {31'b0, halted}, 32'd0);
    expect_reg("R1 reg after reset", 5, 32'd0);

    // Program 1
    load(0,  ri(4'h2, 1, 0, 7));
    load(1,  ri(4'h2, 2, 0, -3));
    load(2,  rr(4'h0, 3, 1, 2));
    load(3,  rr(4'h1, 4, 1, 1));
    load(4,  ri(4'h2, 0, 1, 5));
    load(5,  ri(4'h4, 1, 0, 32'h20));
    load(6,  ri(4'h2, 5, 0, 32'h10000));
    load(7,  ri(4'h3, 6, 5, 32'h20));
    load(8,  rr(4'h8, 1, 2, 1));
    load(9,  ri(4'h2, 7, 0, 99));
    load(10, rr(4'h8, 0, 1, 2));
    load(11, ri(4'h2, 8, 0, 11));
    load(12, rr(4'h8, 2, 1, 1));
    load(13, ri(4'h2, 9, 0, 13));
    load(14, ri(4'h9, 10, 0, 5));
    load(15, ri(4'h5, 0, 0, 1));
    load(16, ri(4'h2, 11, 0, 66));
    load(17, 32'hA000_0000);
    load(18, rr(4'h6, 10, 10, 0));
    load(19, ri(4'h2, 11, 0, 55));
    load(20, ri(4'h9, 13, 0, 2));
    load(21, rr(4'h6, 0, 13, 0));
    load(22, ri(4'h2, 14, 0, 1));
    load(23, rr(4'h8, 0, 6, 1));
    load(24, ri(4'h2, 15, 0, 5));
    load(25, 32'h7000_0000);
    load(26, ri(4'h2, 14, 0, 9));
    @(negedge clk);
    rst = 1'b0;
    run(40);

    check("R8 halted after HALT", {31'b0, halted}, 32'd1);
    expect_reg("R2 ADDI", 1, 32'd7);
    expect_reg("R2 ADDI negative", 2, 32'hFFFF_FFFD);
    expect_reg("R2 ADD", 3, 32'd4);
    expect_reg("R2 NAND", 4, ~32'd7);
    expect_reg("R3 r0 after writes", 0, 32'd0);
    expect_reg("R4 LW truncated address", 6, 32'd7);
    expect_reg("R7 signed lt skip", 7, 32'd0);
    expect_reg("R7 eq no skip", 8, 32'd11);
    expect_reg("R7 mode 2 no skip", 9, 32'd13);
    expect_reg("R6 JALR link same reg", 10, 32'd19);
    expect_reg("R5 GOTO/R6 JALR skipped", 11, 32'd0);
    expect_reg("R5 LEA", 13, 32'd23);
    expect_reg("R6 JALR to r0 target", 14, 32'd0);
    expect_reg("R7 eq skip", 15, 32'd0);

    // R8: frozen while halted
    run(10);
    expect_reg("R8 no change after HALT", 14, 32'd0);

    // R1: reset clears registers and halted, memory kept
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1 halted cleared", {31'b0, halted}, 32'd0);
    expect_reg("R1 reg cleared", 1, 32'd0);
    lockstep();

    // Program 2: loop with backward GOTO, negative store offset
    load(0, ri(4'h2, 1, 0, 3));
    load(1, ri(4'h2, 2, 0, 0));
    load(2, ri(4'h2, 2, 2, 5));
    load(3, ri(4'h2, 1, 1, -1));
    load(4, rr(4'h8, 0, 1, 0));
    load(5, ri(4'h5, 0, 0, -4));
    load(6, ri(4'h2, 3, 0, 40));
    load(7, ri(4'h4, 2, 3, -2));
    load(8, ri(4'h3, 4, 0, 38));
    load(9, 32'h7000_0000);
    @(negedge clk);
    rst = 1'b0;
    run(30);
    expect_reg("R5 backward GOTO loop", 2, 32'd15);
    expect_reg("R7 loop exit skip", 1, 32'd0);
    expect_reg("R4 SW negative offset then LW", 4, 32'd15);
    check("R8 halted program 2", {31'b0, halted}, 32'd1);
    peek(0, v);
    check("R3 dbg r0", v, 32'd0);

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule